// File: doc/BRIEF.md
# Multichannel Capture Address Generator

This block sits between a converter front end and a memory write port. The front end delivers sample words for all active channels in one interleaved stream. The block gives each word a channel number and a memory write address, so that every channel's samples fill a contiguous region of their own. It does not store the raw interleaved sequence. Each region is one waveform pitch long. Channel c starts at the base address plus c times the pitch. Inside its region a channel writes in a circle: its row offset returns to zero after the last row.

Software programs the number of active channels, the pitch and the base address through static register inputs. A start pulse opens a capture and a stop pulse closes it. While a capture runs, the block counts the accepted samples. On a single-cycle trigger strobe it records the write position (channel, row and sample count) in a separate trigger record. That record stays valid until it is acknowledged.

Top module: `acq_addr_gen`

## Requirements
- R1: After reset, `acq_busy`, `in_ready`, `out_valid` and `trg_valid` are all low.
- R2: A start pulse while idle makes `acq_busy` high on the next cycle, and a stop pulse while busy makes it low on the next cycle. A start pulse while busy is ignored and the capture continues without a restart. `in_ready` is low whenever the block is idle.
- R3: `cfg_mode` encodes the active channel count as value+1 (0 = one channel, 3 = four channels). Accepted samples are given channel numbers 0,1,..,N-1 in turn, and numbering restarts at channel 0, row 0 on every accepted start.
- R4: An accepted sample of channel c at row r is written to address base + c*pitch + r, and this value appears on `out_addr`.
- R5: The row offset advances by one after the sample of the last active channel. It returns to 0 instead of reaching the pitch value.
- R6: In single-channel mode, successive samples go to consecutive addresses from the base, wrapping after pitch samples.
- R7: Mode, pitch and base are taken from the inputs only while idle. Changes while a capture runs have no effect on the addresses produced.
- R8: A trigger strobe while busy latches the channel, row and sample count of the next sample to be written. `trg_valid` rises on the next cycle and holds, with the fields unchanged, until `trg_ack`. Further strobes while it is valid are ignored, and strobes while idle are ignored.
- R9: The latched sample count equals the number of samples accepted since the start of the capture.
- R10: While `out_valid` is high and `out_ready` is low, `out_addr`, `out_data` and `out_chan` hold steady and `in_ready` is low.
- R11: A sample accepted on one clock edge is presented on `out_valid`/`out_data` right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Active channel count minus one |
| cfg_pitch | input | PITCH_W | Region length in words |
| cfg_base | input | ADDR_W | Start address of region 0 |
| acq_start | input | 1 | Start-of-capture pulse |
| acq_stop | input | 1 | End-of-capture pulse |
| acq_busy | output | 1 | Capture running |
| in_valid | input | 1 | Sample word offered |
| in_ready | output | 1 | Sample word taken this cycle |
| in_data | input | DATA_W | Sample word |
| trig_strobe | input | 1 | Single-cycle trigger event |
| out_valid | output | 1 | Write request valid |
| out_ready | input | 1 | Write request accepted |
| out_addr | output | ADDR_W | Write address |
| out_data | output | DATA_W | Write data |
| out_chan | output | 2 | Channel of the write |
| trg_valid | output | 1 | Trigger record valid |
| trg_ack | input | 1 | Clears the trigger record |
| trg_chan | output | 2 | Channel at trigger |
| trg_row | output | PITCH_W | Row offset at trigger |
| trg_count | output | CNT_W | Samples accepted before trigger |

## Verification
A sample accepted on an edge shows up as a write request right after that edge. The bench's driver places the expected address, channel and data in a queue at the moment the handshake happens. A monitor samples the outputs on the falling edge, so each transfer is compared exactly once, and during stalls it checks that the request holds. The busy flag and the trigger record change one edge after a start, stop, strobe or acknowledge. These are read one time unit after that edge.

// File: rtl/acqag_pkg.sv
package acqag_pkg;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} acq_state_e;

  typedef enum logic [1:0] {
    MODE_1CH = 2'd0,
    MODE_2CH = 2'd1,
    MODE_3CH = 2'd2,
    MODE_4CH = 2'd3
  } ch_mode_e;

  // highest channel index in use for a given mode
  function automatic logic [1:0] last_chan(input logic [1:0] mode);
    return mode;
  endfunction

  // next channel in interleave order
  function automatic logic [1:0] next_chan(input logic [1:0] chan, input logic [1:0] mode);
    return (chan == last_chan(mode)) ? 2'd0 : chan + 2'd1;
  endfunction

endpackage

// File: rtl/acqag_ctrl.sv
module acqag_ctrl
  import acqag_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int PITCH_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acq_start,
  input  logic               acq_stop,
  input  logic [1:0]         cfg_mode,
  input  logic [PITCH_W-1:0] cfg_pitch,
  input  logic [ADDR_W-1:0]  cfg_base,
  output logic               busy,
  output logic               start_evt,
  output logic [1:0]         mode_q,
  output logic [PITCH_W-1:0] pitch_q,
  output logic [ADDR_W-1:0]  base_q
);

  acq_state_e state_q;
  logic       stop_evt;

  assign start_evt = (state_q == ST_IDLE) && acq_start;
  assign stop_evt  = (state_q == ST_RUN) && acq_stop;
  assign busy      = (state_q == ST_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else if (start_evt) begin
      state_q <= ST_RUN;
    end else if (stop_evt) begin
      state_q <= ST_IDLE;
    end
  end

  // configuration follows the inputs only while idle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= MODE_1CH;
      pitch_q <= '0;
      base_q  <= '0;
    end else if (state_q == ST_IDLE) begin
      mode_q  <= cfg_mode;
      pitch_q <= cfg_pitch;
      base_q  <= cfg_base;
    end
  end

  AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy); // R2
  AST_STOP_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !busy); // R2
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(mode_q) && $stable(pitch_q) && $stable(base_q))); // R7

endmodule

// File: rtl/acqag_position.sv
module acqag_position
  import acqag_pkg::*;
#(
  parameter int PITCH_W = 16,
  parameter int CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               busy,
  input  logic               start_evt,
  input  logic               accept,
  input  logic [1:0]         mode_q,
  input  logic [PITCH_W-1:0] pitch_q,
  output logic [1:0]         chan_idx,
  output logic [PITCH_W-1:0] row_off,
  output logic [CNT_W-1:0]   smp_cnt,
  output logic               frame_end,
  output logic               row_wrap
);

  // row after the current one, circular within the pitch
  function automatic logic [PITCH_W-1:0] next_row(input logic [PITCH_W-1:0] row,
                                                  input logic [PITCH_W-1:0] pitch);
    logic [PITCH_W:0] inc;
    inc = {1'b0, row} + {{PITCH_W{1'b0}}, 1'b1};
    if (inc >= {1'b0, pitch}) return '0;
    return inc[PITCH_W-1:0];
  endfunction

  assign frame_end = accept && (chan_idx == last_chan(mode_q));
  assign row_wrap  = frame_end && (next_row(row_off, pitch_q) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_idx <= '0;
      row_off  <= '0;
      smp_cnt  <= '0;
    end else if (start_evt) begin
      chan_idx <= '0;
      row_off  <= '0;
      smp_cnt  <= '0;
    end else if (accept) begin
      chan_idx <= next_chan(chan_idx, mode_q);
      smp_cnt  <= smp_cnt + {{(CNT_W-1){1'b0}}, 1'b1};
      if (frame_end) row_off <= next_row(row_off, pitch_q);
    end
  end

  AST_CHAN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (chan_idx <= mode_q)); // R3
  AST_ROW_IN_PITCH: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((row_off < pitch_q) || (row_off == '0))); // R5
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (chan_idx == 2'd0 && row_off == '0 && smp_cnt == '0)); // R3
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    row_wrap |=> (row_off == '0 && chan_idx == 2'd0)); // R5
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !start_evt) |=> (smp_cnt == $past(smp_cnt) + 1)); // R9

endmodule

// File: rtl/acqag_trig_rec.sv
module acqag_trig_rec #(
  parameter int PITCH_W = 16,
  parameter int CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               busy,
  input  logic               trig_strobe,
  input  logic               trg_ack,
  input  logic [1:0]         chan_idx,
  input  logic [PITCH_W-1:0] row_off,
  input  logic [CNT_W-1:0]   smp_cnt,
  output logic               trg_valid,
  output logic [1:0]         trg_chan,
  output logic [PITCH_W-1:0] trg_row,
  output logic [CNT_W-1:0]   trg_count
);

  logic trg_capture;

  // the first trigger wins until software acknowledges it
  assign trg_capture = busy && trig_strobe && (!trg_valid || trg_ack);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trg_valid <= 1'b0;
      trg_chan  <= '0;
      trg_row   <= '0;
      trg_count <= '0;
    end else if (trg_capture) begin
      trg_valid <= 1'b1;
      trg_chan  <= chan_idx;
      trg_row   <= row_off;
      trg_count <= smp_cnt;
    end else if (trg_ack) begin
      trg_valid <= 1'b0;
    end
  end

  AST_TRG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (trg_valid && !trg_ack) |=> (trg_valid && $stable(trg_row) && $stable(trg_chan) && $stable(trg_count))); // R8
  AST_TRG_IDLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !trg_valid) |=> !trg_valid); // R8
  AST_TRG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && trig_strobe && !trg_valid) |=> (trg_valid && trg_count == $past(smp_cnt))); // R9

endmodule

// File: rtl/acqag_out_stage.sv
module acqag_out_stage #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] addr_n,
  input  logic [DATA_W-1:0] data_n,
  input  logic [1:0]        chan_n,
  input  logic              out_ready,
  output logic              can_take,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic [1:0]        out_chan
);

  assign can_take = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_addr <= '0;
      out_data <= '0;
      out_chan <= '0;
    end else if (accept) begin
      out_addr <= addr_n;
      out_data <= data_n;
      out_chan <= chan_n;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_data) && $stable(out_chan))); // R10
  AST_NO_TAKE_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !accept); // R10

endmodule

// File: rtl/acq_addr_gen.sv
module acq_addr_gen
  import acqag_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int ADDR_W  = 32,
  parameter int PITCH_W = 16,
  parameter int CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         cfg_mode,
  input  logic [PITCH_W-1:0] cfg_pitch,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic               acq_start,
  input  logic               acq_stop,
  output logic               acq_busy,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_data,
  input  logic               trig_strobe,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [ADDR_W-1:0]  out_addr,
  output logic [DATA_W-1:0]  out_data,
  output logic [1:0]         out_chan,
  output logic               trg_valid,
  input  logic               trg_ack,
  output logic [1:0]         trg_chan,
  output logic [PITCH_W-1:0] trg_row,
  output logic [CNT_W-1:0]   trg_count
);

  // region start of a channel plus its row offset
  function automatic logic [ADDR_W-1:0] region_addr(input logic [ADDR_W-1:0]  base,
                                                    input logic [1:0]         chan,
                                                    input logic [PITCH_W-1:0] pitch,
                                                    input logic [PITCH_W-1:0] row);
    return base + ADDR_W'(chan) * ADDR_W'(pitch) + ADDR_W'(row);
  endfunction

  logic               busy;
  logic               start_evt;
  logic [1:0]         mode_q;
  logic [PITCH_W-1:0] pitch_q;
  logic [ADDR_W-1:0]  base_q;
  logic [1:0]         chan_idx;
  logic [PITCH_W-1:0] row_off;
  logic [CNT_W-1:0]   smp_cnt;
  logic               frame_end;
  logic               row_wrap;
  logic               can_take;
  logic               accept;
  logic [ADDR_W-1:0]  addr_n;

  assign acq_busy = busy;
  assign in_ready = busy && can_take;
  assign accept   = in_valid && in_ready;
  assign addr_n   = region_addr(base_q, chan_idx, pitch_q, row_off);

  acqag_ctrl #(.ADDR_W(ADDR_W), .PITCH_W(PITCH_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .acq_start(acq_start), .acq_stop(acq_stop),
    .cfg_mode(cfg_mode), .cfg_pitch(cfg_pitch), .cfg_base(cfg_base),
    .busy(busy), .start_evt(start_evt), .mode_q(mode_q), .pitch_q(pitch_q), .base_q(base_q)
  );

  acqag_position #(.PITCH_W(PITCH_W), .CNT_W(CNT_W)) pos_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .start_evt(start_evt), .accept(accept),
    .mode_q(mode_q), .pitch_q(pitch_q), .chan_idx(chan_idx), .row_off(row_off),
    .smp_cnt(smp_cnt), .frame_end(frame_end), .row_wrap(row_wrap)
  );

  acqag_trig_rec #(.PITCH_W(PITCH_W), .CNT_W(CNT_W)) trg_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .trig_strobe(trig_strobe), .trg_ack(trg_ack),
    .chan_idx(chan_idx), .row_off(row_off), .smp_cnt(smp_cnt),
    .trg_valid(trg_valid), .trg_chan(trg_chan), .trg_row(trg_row), .trg_count(trg_count)
  );

  acqag_out_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) out_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .addr_n(addr_n), .data_n(in_data),
    .chan_n(chan_idx), .out_ready(out_ready), .can_take(can_take), .out_valid(out_valid),
    .out_addr(out_addr), .out_data(out_data), .out_chan(out_chan)
  );

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (out_valid && out_data == $past(in_data))); // R11
  AST_IDLE_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (!acq_busy && in_valid) |-> !accept); // R2
  AST_ADDR_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (out_addr >= base_q)); // R4

endmodule

// File: tb/acq_addr_gen_tb_top.sv
`timescale 1ns/1ps
module acq_addr_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic [15:0] cfg_pitch = 16'd0;
  logic [31:0] cfg_base = 32'd0;
  logic        acq_start = 1'b0, acq_stop = 1'b0, acq_busy;
  logic        in_valid = 1'b0, in_ready;
  logic [63:0] in_data = 64'd0;
  logic        trig_strobe = 1'b0;
  logic        out_valid, out_ready = 1'b1;
  logic [31:0] out_addr;
  logic [63:0] out_data;
  logic [1:0]  out_chan;
  logic        trg_valid, trg_ack = 1'b0;
  logic [1:0]  trg_chan;
  logic [15:0] trg_row;
  logic [31:0] trg_count;

  always #2 clk = ~clk;

  acq_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_pitch(cfg_pitch), .cfg_base(cfg_base),
    .acq_start(acq_start), .acq_stop(acq_stop), .acq_busy(acq_busy),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .trig_strobe(trig_strobe),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr), .out_data(out_data),
    .out_chan(out_chan), .trg_valid(trg_valid), .trg_ack(trg_ack), .trg_chan(trg_chan),
    .trg_row(trg_row), .trg_count(trg_count)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [63:0] data;
    logic [1:0]  chan;
  } exp_t;

  exp_t   sb_q[$];
  int     n_checks = 0, n_fails = 0;
  bit     done = 1'b0, stall_en = 1'b0;
  string  phase_tag = "R4";

  // independent model of the write position
  int m_last, m_pitch, m_base, m_chan, m_row, m_cnt;
  int e_tchan, e_trow, e_tcnt;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, expv, $time);
    end
  endtask

  // ready pattern: 16-bit shift sequence, roughly three quarters ready
  logic [15:0] lfsr = 16'hACE1;
  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = stall_en ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  // monitor: pop and compare each transfer, and check holding during stalls
  bit          prev_stall = 1'b0;
  logic [31:0] st_addr;
  logic [63:0] st_data;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        check(out_valid && out_addr == st_addr && out_data == st_data, "R10 stall hold",
              longint'(out_addr), longint'(st_addr));
      end
      if (out_valid && out_ready) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R11 unexpected output", longint'(out_addr), 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(out_addr == e.addr, {"R4 address ", phase_tag}, longint'(out_addr), longint'(e.addr));
          check(out_chan == e.chan, "R3 channel", longint'(out_chan), longint'(e.chan));
          check(out_data == e.data, "R11 data", longint'(out_data), longint'(e.data));
        end
      end
      prev_stall = out_valid && !out_ready;
      st_addr = out_addr;
      st_data = out_data;
    end
  end

  task automatic start_cap(input int mode, input int pitch, input int base);
    @(negedge clk);
    cfg_mode = 2'(mode); cfg_pitch = 16'(pitch); cfg_base = 32'(base);
    acq_start = 1'b1;
    @(posedge clk); #1;
    acq_start = 1'b0;
    m_last = mode; m_pitch = pitch; m_base = base; m_chan = 0; m_row = 0; m_cnt = 0;
    check(acq_busy == 1'b1, "R2 busy after start", longint'(acq_busy), 1);
  endtask

  task automatic stop_cap();
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
    acq_stop = 1'b1;
    @(posedge clk); #1;
    acq_stop = 1'b0;
    check(acq_busy == 1'b0, "R2 idle after stop", longint'(acq_busy), 0);
  endtask

  task automatic send(input logic [63:0] d, input bit trig);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_data = d; trig_strobe = trig;
    if (trig && !trg_valid) begin
      e_tchan = m_chan; e_trow = m_row; e_tcnt = m_cnt;
    end
    #1;
    while (!in_ready) begin
      @(negedge clk);
      trig_strobe = 1'b0;
      #1;
    end
    e.addr = 32'(m_base + m_chan * m_pitch + m_row);
    e.data = d;
    e.chan = 2'(m_chan);
    sb_q.push_back(e);
    m_cnt++;
    if (m_chan == m_last) begin
      m_chan = 0;
      m_row = (m_row + 1 >= m_pitch) ? 0 : m_row + 1;
    end else begin
      m_chan++;
    end
    @(posedge clk); #1;
    in_valid = 1'b0; trig_strobe = 1'b0;
    if (!stall_en) begin
      check(out_valid && out_data == d, "R11 one-cycle latency", longint'(out_data), longint'(d));
    end
  endtask

  task automatic check_trig(input string req);
    check(trg_valid == 1'b1, {req, " valid"}, longint'(trg_valid), 1);
    check(trg_chan == 2'(e_tchan), {req, " channel"}, longint'(trg_chan), longint'(e_tchan));
    check(trg_row == 16'(e_trow), {req, " row"}, longint'(trg_row), longint'(e_trow));
    check(trg_count == 32'(e_tcnt), "R9 sample count", longint'(trg_count), longint'(e_tcnt));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(acq_busy == 1'b0, "R1 busy", longint'(acq_busy), 0);
    check(in_ready == 1'b0, "R1 in_ready", longint'(in_ready), 0);
    check(out_valid == 1'b0, "R1 out_valid", longint'(out_valid), 0);
    check(trg_valid == 1'b0, "R1 trg_valid", longint'(trg_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: idle refuses samples; R8: idle trigger ignored
    @(negedge clk);
    in_valid = 1'b1; trig_strobe = 1'b1;
    #1;
    check(in_ready == 1'b0, "R2 idle in_ready", longint'(in_ready), 0);
    @(posedge clk); #1;
    in_valid = 1'b0; trig_strobe = 1'b0;
    @(posedge clk); #1;
    check(trg_valid == 1'b0, "R8 idle trigger ignored", longint'(trg_valid), 0);
    check(out_valid == 1'b0, "R2 idle sample ignored", longint'(out_valid), 0);

    // R6 and R5: single channel, pitch 8, wraps twice
    phase_tag = "R6";
    start_cap(0, 8, 'h100);
    for (int i = 0; i < 20; i++) send(64'(i) + 64'h1000, 1'b0);
    stop_cap();

    // R7 and R10: two channels with stalls, config and start changed mid-capture
    phase_tag = "R7";
    stall_en = 1'b1;
    start_cap(1, 6, 'h2000);
    for (int i = 0; i < 30; i++) begin
      if (i == 9) begin
        @(negedge clk);
        cfg_pitch = 16'd9; cfg_mode = 2'd3; cfg_base = 32'h9000;
        acq_start = 1'b1;                 // R2: start while busy ignored
        @(posedge clk); #1;
        acq_start = 1'b0;
      end
      send(64'(i) * 64'h11 + 64'h2000_0000, 1'b0);
    end
    stop_cap();
    stall_en = 1'b0;

    // R8 and R9: three channels, trigger record
    phase_tag = "R5";
    start_cap(2, 5, 'h3000);
    for (int i = 0; i < 7; i++) send(64'(i) + 64'h3000, 1'b0);
    send(64'h3007, 1'b1);
    check_trig("R8 first trigger");
    send(64'h3008, 1'b1);                  // ignored: record already valid
    send(64'h3009, 1'b0);
    check_trig("R8 second strobe ignored");
    @(negedge clk);
    trg_ack = 1'b1;
    @(posedge clk); #1;
    trg_ack = 1'b0;
    check(trg_valid == 1'b0, "R8 cleared by ack", longint'(trg_valid), 0);
    send(64'h300A, 1'b1);
    check_trig("R8 new trigger after ack");
    for (int i = 11; i < 20; i++) send(64'(i) + 64'h3000, 1'b0);
    stop_cap();
    @(negedge clk);
    trg_ack = 1'b1;
    @(posedge clk); #1;
    trg_ack = 1'b0;

    // R3: four channels with stalls, then restart from channel 0
    phase_tag = "R3";
    stall_en = 1'b1;
    start_cap(3, 3, 'h40);
    for (int i = 0; i < 26; i++) send(64'(i) + 64'h4000, 1'b0);
    stop_cap();
    start_cap(3, 3, 'h40);
    for (int i = 0; i < 5; i++) send(64'(i) + 64'h5000, 1'b0);
    stop_cap();
    stall_en = 1'b0;

    repeat (4) @(negedge clk);
    check(sb_q.size() == 0, "R11 all outputs seen", longint'(sb_q.size()), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule